// File: doc/BRIEF.md
# Deep-Sleep Clock Source Sequencer

This block picks the system clock source and divider for a power-managed chip. Four oscillators can be chosen: the main crystal oscillator, the internal precision oscillator, a low-frequency internal oscillator and a real-time-clock oscillator. One configuration applies in run and sleep. A second configuration applies in deep sleep. On a sleep request the sequencer first records the source and divider that are in use. It then stops the clocks named in a gate mask and moves the system clock to the deep-sleep source. On a wake event it works through these steps in the reverse order. It returns to the recorded source and divider, waits for that oscillator to report ready, and only after that turns the gated clocks back on.

The deep-sleep configuration can ask for the main oscillator while run mode uses some other oscillator. This combination is resolved when deep sleep is entered. If the precision oscillator stays powered through deep sleep, it is used in place of the main oscillator. If it is set to power down, the sequencer still enters deep sleep, but it raises a sticky error flag and never leaves deep sleep until reset. Each peripheral also has a baud-clock select, which picks either the precision oscillator or an alternate clock. During deep sleep the same selected clock drives that peripheral's module clock.

Top module: `dsclk_seq`

## Requirements
- R1: After reset, sys_src is 1 (precision oscillator), sys_div is 0, every gate_en bit is 1, prec_pwr_en is 1, and ds_active, err_wake, periph_baud_alt and periph_mod_sel are all 0.
- R2: In run mode, a write to address 0 sets the run source from cfg_wdata[1:0] (0 main, 1 precision, 2 low-frequency, 3 RTC) and the run divider from cfg_wdata[5:2]. sys_src and sys_div follow these values within three cycles.
- R3: After sleep_req, gate_en first changes to the inverse of the gate mask (address 2, one bit per clock, 1 means stop) while sys_src still shows the run source. After that, sys_src and sys_div move to the deep-sleep values (address 1: source [1:0], divider [5:2], precision power-down [6]), and ds_active rises once that source's osc_rdy bit is 1.
- R4: If the deep-sleep source is main, the run source is not main, and power-down is 0, then the deep-sleep source used is the precision oscillator and err_wake stays 0.
- R5: If the deep-sleep source is main, the run source is not main, and power-down is 1, then the block enters deep sleep on main and sets err_wake. err_wake stays set, and ds_active stays 1 through any wake event until reset.
- R6: prec_pwr_en is 0 only while ds_active is 1, power-down was 1 at entry, and the deep-sleep source used is not the precision oscillator. It is 1 again when the wake sequence starts.
- R7: On wake_evt in deep sleep, sys_src and sys_div return to their values at entry, and ds_active falls. gate_en goes back to all ones only after osc_rdy for the restored source is 1, and never before.
- R8: A wake_evt that arrives after sleep_req but before ds_active is held. The block passes through deep sleep and wakes without a further event. A wake_evt seen in run mode has no effect on a later deep sleep.
- R9: Configuration writes (to any address) are ignored at every point except run mode. A run-source write made during deep sleep does not change sys_src after wake. A mask write made during deep sleep does not change the gating of the next deep sleep.
- R10: periph_baud_alt equals the per-peripheral select bits (address 3, 1 = alternate clock). periph_mod_sel holds a 2-bit code per peripheral: it is 0 (system clock) outside deep sleep, and in deep sleep it is 1 (precision) or 2 (alternate) according to that peripheral's select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 run, 1 deep sleep, 2 gate mask, 3 peripheral select |
| cfg_wdata | input | CFG_W (8) | Write data |
| sleep_req | input | 1 | Deep-sleep request, sampled in run mode |
| wake_evt | input | 1 | Deep-sleep exit event |
| osc_rdy | input | 4 | Ready per oscillator, indexed by source code |
| sys_src | output | 2 | Selected system clock source code |
| sys_div | output | DIVW (4) | Selected system clock divider |
| gate_en | output | NG (8) | Clock enables, 1 = running |
| prec_pwr_en | output | 1 | Precision oscillator power enable |
| periph_baud_alt | output | NP (4) | Baud clock uses alternate clock, per peripheral |
| periph_mod_sel | output | 2*NP (8) | Module clock code per peripheral |
| ds_active | output | 1 | Deep sleep in effect |
| err_wake | output | 1 | Unrecoverable deep-sleep combination detected |

## Verification
If the sequencer holds the wrong state, the wrong order of events shows at the ports within a cycle or two. Gates can reopen while sys_src still differs from the run source. sys_src can change before the gates close. ds_active can appear without the osc_rdy it waits for. A latched value that was lost or corrupted appears as a wrong sys_src or sys_div on the first cycle after wake, or as a gate mask that does not match the one programmed before entry. A missing pending wake, or an error that is not sticky, shows up as ds_active that stays or falls against expectation within a few tens of cycles.

// File: rtl/dsclk_pkg.sv
`timescale 1ns/1ps
// Shared types for the deep-sleep clock sequencer.
// Assumes source codes double as indices into the oscillator ready vector.
package dsclk_pkg;

    typedef enum logic [1:0] {
        SRC_MAIN = 2'd0,
        SRC_PREC = 2'd1,
        SRC_LFO  = 2'd2,
        SRC_RTC  = 2'd3
    } clk_src_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SAVE_CFG,
        ST_GATE_CLOCKS,
        ST_SWITCH_DS,
        ST_DEEP_SLEEP,
        ST_RESTORE_SRC,
        ST_WAIT_READY,
        ST_UNGATE
    } seq_state_e;

    localparam logic [1:0] PMOD_SYS  = 2'd0;
    localparam logic [1:0] PMOD_PREC = 2'd1;
    localparam logic [1:0] PMOD_ALT  = 2'd2;

    localparam logic [1:0] ADDR_RUN   = 2'd0;
    localparam logic [1:0] ADDR_DS    = 2'd1;
    localparam logic [1:0] ADDR_MASK  = 2'd2;
    localparam logic [1:0] ADDR_PSEL  = 2'd3;

endpackage

// File: rtl/dsclk_cfg.sv
`timescale 1ns/1ps
// Configuration register bank.
// Holds run and deep-sleep source/divider, the precision power-down bit,
// the gate mask and the peripheral clock selects. Writes land only while
// the accept input is high (sequencer in run mode).
// Assumes CFG_W >= max(NG, NP, DIVW+3).
module dsclk_cfg
    import dsclk_pkg::*;
#(
    parameter int CFG_W = 8,
    parameter int DIVW  = 4,
    parameter int NG    = 8,
    parameter int NP    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             accept,
    output clk_src_e         run_src,
    output logic [DIVW-1:0]  run_div,
    output clk_src_e         ds_src,
    output logic [DIVW-1:0]  ds_div,
    output logic             ds_prec_pd,
    output logic [NG-1:0]    gate_mask,
    output logic [NP-1:0]    periph_cs
);
    localparam int DIV_LO = 2;
    localparam int DIV_HI = DIV_LO + DIVW - 1;
    localparam int PD_BIT = DIV_HI + 1;

    // Register update: accepted writes only, reset to precision/undivided.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_src    <= SRC_PREC;
            run_div    <= '0;
            ds_src     <= SRC_PREC;
            ds_div     <= '0;
            ds_prec_pd <= 1'b0;
            gate_mask  <= '0;
            periph_cs  <= '0;
        end else if (wr_en && accept) begin
            case (wr_addr)
                ADDR_RUN: begin
                    run_src <= clk_src_e'(wr_data[1:0]);
                    run_div <= wr_data[DIV_HI:DIV_LO];
                end
                ADDR_DS: begin
                    ds_src     <= clk_src_e'(wr_data[1:0]);
                    ds_div     <= wr_data[DIV_HI:DIV_LO];
                    ds_prec_pd <= wr_data[PD_BIT];
                end
                ADDR_MASK: gate_mask <= wr_data[NG-1:0];
                default:   periph_cs <= wr_data[NP-1:0];
            endcase
        end
    end
endmodule

// File: rtl/dsclk_resolve.sv
`timescale 1ns/1ps
// Deep-sleep source resolution.
// A main-oscillator deep-sleep request while run mode uses another source
// is replaced by the precision oscillator when that stays powered, and is
// flagged as unrecoverable when it does not. Purely combinational.
module dsclk_resolve
    import dsclk_pkg::*;
(
    input  clk_src_e run_src,
    input  clk_src_e ds_src,
    input  logic     prec_pd,
    output clk_src_e eff_src,
    output logic     bad_combo
);
    // Pick the source actually used in deep sleep and flag a dead end.
    always_comb begin
        eff_src   = ds_src;
        bad_combo = 1'b0;
        if (ds_src == SRC_MAIN && run_src != SRC_MAIN) begin
            if (prec_pd) begin
                bad_combo = 1'b1;
            end else begin
                eff_src = SRC_PREC;
            end
        end
    end
endmodule

// File: rtl/dsclk_periph_mux.sv
`timescale 1ns/1ps
// Peripheral module clock selection.
// Outside deep sleep each peripheral runs its module clock from the system
// clock; in deep sleep the module clock follows its baud source.
module dsclk_periph_mux
    import dsclk_pkg::*;
#(
    parameter int NP = 4
) (
    input  logic            ds_active,
    input  logic [NP-1:0]   cs,
    output logic [2*NP-1:0] mod_sel
);
    for (genvar i = 0; i < NP; i++) begin : g_periph
        // Per-peripheral module clock code.
        always_comb begin
            if (!ds_active)  mod_sel[2*i +: 2] = PMOD_SYS;
            else if (cs[i])  mod_sel[2*i +: 2] = PMOD_ALT;
            else             mod_sel[2*i +: 2] = PMOD_PREC;
        end
    end
endmodule

// File: rtl/dsclk_seq_fsm.sv
`timescale 1ns/1ps
// Entry/exit sequencer.
// Entry: record source and divider, close gates, switch to the resolved
// deep-sleep source, wait for it to be ready. Exit: restore the recorded
// source, wait for its ready, then reopen all gates. A wake seen during
// entry is held. An unrecoverable entry never leaves deep sleep.
module dsclk_seq_fsm
    import dsclk_pkg::*;
#(
    parameter int DIVW = 4,
    parameter int NG   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_req,
    input  logic            wake_evt,
    input  logic [3:0]      osc_rdy,
    input  clk_src_e        run_src,
    input  logic [DIVW-1:0] run_div,
    input  logic [DIVW-1:0] ds_div,
    input  logic            prec_pd,
    input  clk_src_e        eff_src,
    input  logic            bad_combo,
    input  logic [NG-1:0]   gate_mask,
    output seq_state_e      state,
    output clk_src_e        cur_src,
    output logic [DIVW-1:0] cur_div,
    output logic [NG-1:0]   gate_en,
    output logic            prec_pwr_en,
    output logic            err_wake
);
    clk_src_e        save_src;
    logic [DIVW-1:0] save_div;
    clk_src_e        lat_eff;
    logic [DIVW-1:0] lat_div;
    logic            lat_pd;
    logic            wake_pend;
    logic            in_entry;
    logic            wake_go;

    assign in_entry = (state == ST_SAVE_CFG) || (state == ST_GATE_CLOCKS) ||
                      (state == ST_SWITCH_DS);
    assign wake_go  = (wake_evt || wake_pend) && !err_wake;

    // Hold a wake that arrives before deep sleep is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)                        wake_pend <= 1'b0;
        else if (in_entry && wake_evt)     wake_pend <= 1'b1;
        else if (state == ST_RESTORE_SRC)  wake_pend <= 1'b0;
    end

    // Main sequence: state, selected clock, gates and latched settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            cur_src  <= SRC_PREC;
            cur_div  <= '0;
            gate_en  <= '1;
            save_src <= SRC_PREC;
            save_div <= '0;
            lat_eff  <= SRC_PREC;
            lat_div  <= '0;
            lat_pd   <= 1'b0;
            err_wake <= 1'b0;
        end else begin
            case (state)
                ST_RUN: begin
                    cur_src <= run_src;
                    cur_div <= run_div;
                    if (sleep_req) state <= ST_SAVE_CFG;
                end
                ST_SAVE_CFG: begin
                    save_src <= cur_src;
                    save_div <= cur_div;
                    lat_eff  <= eff_src;
                    lat_div  <= ds_div;
                    lat_pd   <= prec_pd;
                    err_wake <= err_wake | bad_combo;
                    state    <= ST_GATE_CLOCKS;
                end
                ST_GATE_CLOCKS: begin
                    gate_en <= ~gate_mask;
                    state   <= ST_SWITCH_DS;
                end
                ST_SWITCH_DS: begin
                    cur_src <= lat_eff;
                    cur_div <= lat_div;
                    if (osc_rdy[lat_eff]) state <= ST_DEEP_SLEEP;
                end
                ST_DEEP_SLEEP: begin
                    if (wake_go) state <= ST_RESTORE_SRC;
                end
                ST_RESTORE_SRC: begin
                    cur_src <= save_src;
                    cur_div <= save_div;
                    state   <= ST_WAIT_READY;
                end
                ST_WAIT_READY: begin
                    if (osc_rdy[save_src]) state <= ST_UNGATE;
                end
                default: begin
                    gate_en <= '1;
                    state   <= ST_RUN;
                end
            endcase
        end
    end

    // Precision oscillator power: off only in deep sleep when asked and unused.
    always_comb begin
        prec_pwr_en = !((state == ST_DEEP_SLEEP) && lat_pd && (lat_eff != SRC_PREC));
    end
endmodule

// File: rtl/dsclk_seq.sv
`timescale 1ns/1ps
// Deep-sleep clock source sequencer, top level.
// Ties the register bank, source resolution, entry/exit sequencer and the
// peripheral module clock mux together. Oscillators and glitch-free clock
// switches live outside; this block drives their selects and reads ready.
module dsclk_seq
    import dsclk_pkg::*;
#(
    parameter int DIVW  = 4,
    parameter int NG    = 8,
    parameter int NP    = 4,
    parameter int CFG_W = (NG > DIVW + 3) ? ((NG > NP) ? NG : NP)
                                          : ((DIVW + 3 > NP) ? DIVW + 3 : NP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             sleep_req,
    input  logic             wake_evt,
    input  logic [3:0]       osc_rdy,
    output logic [1:0]       sys_src,
    output logic [DIVW-1:0]  sys_div,
    output logic [NG-1:0]    gate_en,
    output logic             prec_pwr_en,
    output logic [NP-1:0]    periph_baud_alt,
    output logic [2*NP-1:0]  periph_mod_sel,
    output logic             ds_active,
    output logic             err_wake
);
    seq_state_e      state;
    clk_src_e        run_src;
    logic [DIVW-1:0] run_div;
    clk_src_e        ds_src;
    logic [DIVW-1:0] ds_div;
    logic            ds_prec_pd;
    logic [NG-1:0]   gate_mask;
    logic [NP-1:0]   periph_cs;
    clk_src_e        eff_src;
    logic            bad_combo;
    clk_src_e        cur_src;

    dsclk_cfg #(.CFG_W(CFG_W), .DIVW(DIVW), .NG(NG), .NP(NP)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_addr    (cfg_addr),
        .wr_data    (cfg_wdata),
        .accept     (state == ST_RUN),
        .run_src    (run_src),
        .run_div    (run_div),
        .ds_src     (ds_src),
        .ds_div     (ds_div),
        .ds_prec_pd (ds_prec_pd),
        .gate_mask  (gate_mask),
        .periph_cs  (periph_cs)
    );

    dsclk_resolve u_resolve (
        .run_src   (run_src),
        .ds_src    (ds_src),
        .prec_pd   (ds_prec_pd),
        .eff_src   (eff_src),
        .bad_combo (bad_combo)
    );

    dsclk_seq_fsm #(.DIVW(DIVW), .NG(NG)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .wake_evt    (wake_evt),
        .osc_rdy     (osc_rdy),
        .run_src     (run_src),
        .run_div     (run_div),
        .ds_div      (ds_div),
        .prec_pd     (ds_prec_pd),
        .eff_src     (eff_src),
        .bad_combo   (bad_combo),
        .gate_mask   (gate_mask),
        .state       (state),
        .cur_src     (cur_src),
        .cur_div     (sys_div),
        .gate_en     (gate_en),
        .prec_pwr_en (prec_pwr_en),
        .err_wake    (err_wake)
    );

    dsclk_periph_mux #(.NP(NP)) u_pmux (
        .ds_active (ds_active),
        .cs        (periph_cs),
        .mod_sel   (periph_mod_sel)
    );

    assign sys_src         = cur_src;
    assign ds_active       = (state == ST_DEEP_SLEEP);
    assign periph_baud_alt = periph_cs;
endmodule

// File: rtl/dsclk_seq_chk.sv
`timescale 1ns/1ps
// Property checker for the deep-sleep clock sequencer, bound to the top.
// Watches ports plus the sequencer state and run configuration registers.
module dsclk_seq_chk
    import dsclk_pkg::*;
#(
    parameter int DIVW = 4,
    parameter int NG   = 8,
    parameter int NP   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      state_q,
    input logic [1:0]      run_src_q,
    input logic [DIVW-1:0] run_div_q,
    input logic [1:0]      sys_src,
    input logic [NG-1:0]   gate_en,
    input logic            prec_pwr_en,
    input logic [2*NP-1:0] periph_mod_sel,
    input logic            ds_active,
    input logic            err_wake
);
    localparam logic [NG-1:0] ALL_ON = '1;

    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |=> ($stable(run_src_q) && $stable(run_div_q)));

    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_wake |=> err_wake);

    a_r5_no_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (err_wake && ds_active) |=> ds_active);

    a_r6_prec_off_in_ds: assert property (@(posedge clk) disable iff (!rst_n)
        !prec_pwr_en |-> ds_active);

    a_r7_ungate_late: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en == ALL_ON && $past(gate_en) != ALL_ON) |->
            (!ds_active && $stable(sys_src)));

    a_r10_mod_run: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_active |-> (periph_mod_sel == '0));
endmodule

bind dsclk_seq dsclk_seq_chk #(.DIVW(DIVW), .NG(NG), .NP(NP)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .state_q        (state),
    .run_src_q      (run_src),
    .run_div_q      (run_div),
    .sys_src        (sys_src),
    .gate_en        (gate_en),
    .prec_pwr_en    (prec_pwr_en),
    .periph_mod_sel (periph_mod_sel),
    .ds_active      (ds_active),
    .err_wake       (err_wake)
);

// File: tb/dsclk_seq_test.sv
`timescale 1ns/1ps
// Bench for the deep-sleep clock sequencer: a vector table of sleep/wake
// round trips, then directed tests for reset, pending wake, ready wait,
// ignored writes, peripheral selects and the unrecoverable combination.
module dsclk_seq_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [1:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic       sleep_req;
    logic       wake_evt;
    logic [3:0] osc_rdy;
    logic [1:0] sys_src;
    logic [3:0] sys_div;
    logic [7:0] gate_en;
    logic       prec_pwr_en;
    logic [3:0] periph_baud_alt;
    logic [7:0] periph_mod_sel;
    logic       ds_active;
    logic       err_wake;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dsclk_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .sleep_req(sleep_req), .wake_evt(wake_evt),
        .osc_rdy(osc_rdy), .sys_src(sys_src), .sys_div(sys_div),
        .gate_en(gate_en), .prec_pwr_en(prec_pwr_en),
        .periph_baud_alt(periph_baud_alt), .periph_mod_sel(periph_mod_sel),
        .ds_active(ds_active), .err_wake(err_wake)
    );

    // Row: run_src, run_div, ds_src, ds_div, pd, mask, exp_src, exp_poff, exp_err
    localparam int NV = 5;
    localparam logic [24:0] VEC [NV] = '{
        {2'd0, 4'd3, 2'd0, 4'd5, 1'b1, 8'hF0, 2'd0, 1'b1, 1'b0},
        {2'd1, 4'd2, 2'd2, 4'd7, 1'b0, 8'h0F, 2'd2, 1'b0, 1'b0},
        {2'd2, 4'd1, 2'd0, 4'd4, 1'b0, 8'hAA, 2'd1, 1'b0, 1'b0},
        {2'd3, 4'd6, 2'd3, 4'd9, 1'b1, 8'h55, 2'd3, 1'b1, 1'b0},
        {2'd1, 4'd0, 2'd1, 4'd2, 1'b1, 8'hFF, 2'd1, 1'b0, 1'b0}
    };

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1; tick(1); sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_evt = 1'b1; tick(1); wake_evt = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(1);
    endtask

    task automatic wait_ds(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            tick(1);
            if (ds_active) seen = 1'b1;
        end
    endtask

    task automatic wait_ungated(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            tick(1);
            if (gate_en == 8'hFF) seen = 1'b1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        bit seen;
        bit gate_seen;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        sleep_req = 1'b0; wake_evt = 1'b0; osc_rdy = 4'hF;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        check(sys_src == 2'd1, "R1 src", sys_src, 1);
        check(sys_div == 4'd0, "R1 div", sys_div, 0);
        check(gate_en == 8'hFF, "R1 gates", gate_en, 8'hFF);
        check(prec_pwr_en && !ds_active && !err_wake, "R1 flags",
              {prec_pwr_en, ds_active, err_wake}, 3'b100);
        check(periph_baud_alt == 0 && periph_mod_sel == 0, "R1 periph",
              {periph_baud_alt, periph_mod_sel}, 0);

        // Table walk: R2, R3, R4, R6, R7
        for (int v = 0; v < NV; v++) begin
            logic [1:0] rs, ds, es;
            logic [3:0] rd, dd;
            logic       pd, poff;
            logic [7:0] mk;
            {rs, rd, ds, dd, pd, mk, es, poff} = VEC[v][24:1];
            wr(2'd0, {2'b00, rd, rs});
            wr(2'd1, {1'b0, pd, dd, ds});
            wr(2'd2, mk);
            tick(3);
            check(sys_src == rs && sys_div == rd, "R2 run cfg",
                  {sys_src, sys_div}, {rs, rd});
            pulse_sleep();
            gate_seen = 1'b0;
            for (int i = 0; i < 40 && !gate_seen; i++) begin
                if (gate_en != 8'hFF) begin
                    gate_seen = 1'b1;
                    check(sys_src == rs && !ds_active, "R3 gate before switch",
                          sys_src, rs);
                end else tick(1);
            end
            check(gate_seen, "R3 gates closed", gate_seen, 1);
            wait_ds(seen);
            check(seen, "R3 ds_active", seen, 1);
            check(sys_src == es && sys_div == dd, "R4 deep src/div",
                  {sys_src, sys_div}, {es, dd});
            check(gate_en == ~mk, "R3 gate pattern", gate_en, ~mk);
            check(prec_pwr_en == !poff, "R6 prec power", prec_pwr_en, !poff);
            check(err_wake == VEC[v][0], "R4 no error", err_wake, VEC[v][0]);
            pulse_wake();
            wait_ungated(seen);
            check(seen && sys_src == rs && sys_div == rd && !ds_active && prec_pwr_en,
                  "R7 restore", {sys_src, sys_div}, {rs, rd});
            tick(2);
        end

        // R7: ungate waits for restored oscillator ready
        wr(2'd0, 8'h08);            // main, div 2
        wr(2'd1, 8'h05);            // precision, div 1
        wr(2'd2, 8'h3C);
        tick(3);
        pulse_sleep();
        wait_ds(seen);
        osc_rdy = 4'hE;
        pulse_wake();
        tick(10);
        check(gate_en == 8'hC3 && sys_src == 2'd0 && sys_div == 4'd2 && !ds_active,
              "R7 held gated", {gate_en, sys_src}, {8'hC3, 2'd0});
        osc_rdy = 4'hF;
        tick(3);
        check(gate_en == 8'hFF, "R7 ungate after ready", gate_en, 8'hFF);

        // R9: writes during deep sleep are ignored
        pulse_sleep();
        wait_ds(seen);
        wr(2'd0, 8'h3F);
        wr(2'd2, 8'h00);
        pulse_wake();
        wait_ungated(seen);
        tick(4);
        check(sys_src == 2'd0 && sys_div == 4'd2, "R9 run cfg kept",
              {sys_src, sys_div}, {2'd0, 4'd2});
        pulse_sleep();
        wait_ds(seen);
        check(gate_en == 8'hC3, "R9 mask kept", gate_en, 8'hC3);
        pulse_wake();
        wait_ungated(seen);
        tick(2);

        // R10 peripheral selects
        wr(2'd3, 8'h05);
        tick(1);
        check(periph_baud_alt == 4'h5 && periph_mod_sel == 8'h00, "R10 run",
              {periph_baud_alt, periph_mod_sel}, 12'h500);
        pulse_sleep();
        wait_ds(seen);
        check(periph_mod_sel == 8'h66, "R10 deep", periph_mod_sel, 8'h66);
        pulse_wake();
        wait_ungated(seen);
        tick(2);

        // R8: wake in run has no effect
        pulse_wake();
        tick(2);
        pulse_sleep();
        wait_ds(seen);
        tick(5);
        check(ds_active, "R8 run wake ignored", ds_active, 1);
        pulse_wake();
        wait_ungated(seen);
        tick(2);

        // R8: wake during entry is held
        sleep_req = 1'b1; tick(1); sleep_req = 1'b0;
        wake_evt = 1'b1; tick(1); wake_evt = 1'b0;
        seen = 1'b0;
        gate_seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (ds_active) seen = 1'b1;
            if (seen && !ds_active && gate_en == 8'hFF) gate_seen = 1'b1;
            tick(1);
        end
        check(seen && gate_seen, "R8 pending wake", {seen, gate_seen}, 2'b11);

        // R5: unrecoverable combination
        do_reset();
        wr(2'd0, 8'h02);            // low-frequency run
        wr(2'd1, 8'h40);            // main deep, power-down
        wr(2'd2, 8'h0F);
        tick(2);
        pulse_sleep();
        wait_ds(seen);
        check(seen && err_wake && sys_src == 2'd0, "R5 error entry",
              {err_wake, sys_src}, {1'b1, 2'd0});
        check(!prec_pwr_en, "R6 prec off", prec_pwr_en, 0);
        pulse_wake();
        tick(20);
        check(ds_active && err_wake && gate_en == 8'hF0, "R5 stuck",
              {ds_active, err_wake, gate_en}, {2'b11, 8'hF0});
        do_reset();
        check(!err_wake && !ds_active && gate_en == 8'hFF, "R1 after reset",
              {err_wake, ds_active}, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule